// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synchronous, byte-writable static memory with one shared data bus, split here into an input word, an output word and a driver-enable pin. It accepts a new command on every enabled clock. Reads and writes may follow each other in any order with no idle cycles between them. To make that possible, the data of a write is placed on the bus two enabled cycles after its command. This is the same cycle in which a read issued at that point would return its word. A read that targets a write still in flight gets the new bytes through forwarding.

Each command is captured with an address, a write strobe, two byte-write selects, three chip selects and a load/advance control. A load starts a new command at the given address. An advance steps a 2-bit burst counter and repeats the previous command type at the next address of a four-word group. The group is walked in either linear or interleaved order, chosen when the burst is loaded. A low clock enable freezes the whole pipeline. An asynchronous output enable gates the bus drivers without waiting for a clock.

Top module: `pipe_sram`

## Requirements
- R1: After reset, and until a read reaches its data phase, `dq_oe` is 0.
- R2: A read loaded in enabled cycle t drives the stored word on `dq_o`, with `dq_oe`=1 while `oe_n`=0, for the whole of enabled cycle t+2.
- R3: For a write loaded in enabled cycle t, `dq_i` is sampled in enabled cycle t+2. `bw_n[0]`=0 updates bits 8:0 and `bw_n[1]`=0 updates bits 17:9. A byte whose select is 1 keeps its old contents.
- R4: Commands in any read/write mix are accepted on consecutive enabled cycles. A read issued right after a write to the same address returns the newly written bytes merged with the old ones.
- R5: A load is a command only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 all hold. Any other combination is a deselect: memory is unchanged and `dq_oe` is 0 two enabled cycles later.
- R6: During the data phase of a write, `dq_oe` is 0.
- R7: `oe_n`=1 forces `dq_oe` to 0 at once, without a clock edge. Returning `oe_n` to 0 restores the drive.
- R8: An edge with `clk_en`=0 is ignored. Every command input is disregarded, and the bus phase in progress (output word, drive state, pending write) is extended unchanged.
- R9: `adv`=1 steps the burst counter n (0 at load, then 1, 2, 3, 0 ...). With `burst_ilv`=0 at load, the address low bits are (start+n) mod 4. The upper address bits stay those of the load.
- R10: With `burst_ilv`=1 at load, the address low bits of an advanced command are start XOR n.
- R11: An advance repeats the command type of the last load (read, write or deselect). On an advance, `we_n` and the three chip selects are ignored, but `bw_n` applies.

Note: advanced commands use 2-bit offset codes; the address must be at least 3 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable, active high |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 advances the burst, 0 loads a new command |
| we_n | input | 1 | 0 writes, 1 reads (on load) |
| bw_n | input | 2 | Byte-write selects, active low (bit 0 covers data 8:0) |
| burst_ilv | input | 1 | Burst order captured at load: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 18 | Data bus as seen by the memory |
| dq_o | output | 18 | Data the memory drives |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The bench configures a 16-word memory. It fills every word, reads all of them back, and then sweeps all four byte-select codes over several addresses. Each write is followed directly by a read of the same address, which separates correct forwarding from a stale array read. A read after an intervening idle or unrelated read shows the committed array value. A strict read/write alternation over mismatched addresses shows that forwarding fires only on an address match. All eight chip-select combinations, linear and interleaved bursts from every start offset (including a wrap past four steps), advances after a deselected load, and irregular clock-enable stalls carrying garbage commands each separate a different control path from the rest. Toggling the output enable in mid-cycle exposes any clocked gating of the drivers.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int BYTE_W  = 9;
  localparam int N_BYTES = 2;
  localparam int WORD_W  = BYTE_W * N_BYTES;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low address bits of burst step 'step' from offset 'start'.
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

  // Take the bytes of new_w whose bit in 'take' is set, the rest from old_w.
  function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0]  old_w,
                                                    input logic [WORD_W-1:0]  new_w,
                                                    input logic [N_BYTES-1:0] take);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int b = 0; b < N_BYTES; b++)
      if (take[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction
endpackage

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              we_n,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic [1:0]        step_nx;
  logic              ilv_q;
  op_e               last_q;

  assign step_nx = step_q + 2'd1;

  always_comb begin
    if (!adv) begin
      cmd_op   = !sel_ok ? OP_IDLE : (we_n ? OP_RD : OP_WR);
      cmd_addr = addr;
    end else begin
      cmd_op   = last_q;
      cmd_addr = {base_q[ADDR_W-1:2], burst_offset(base_q[1:0], step_nx, ilv_q)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      ilv_q  <= 1'b0;
      last_q <= OP_IDLE;
    end else if (clk_en) begin
      if (!adv) begin
        base_q <= addr;
        step_q <= '0;
        ilv_q  <= ilv;
        last_q <= cmd_op;
      end else begin
        step_q <= step_nx;
      end
    end
  end

  // R11: an advance never alters the remembered command type
  assert_adv_keeps_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv) |=> $stable(last_q));
  // R9: an advance keeps the loaded base (upper bits come from it)
  assert_adv_keeps_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv) |=> $stable(base_q));
endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               clk_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [N_BYTES-1:0] wr_be,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               fwd_hit,
  output logic [WORD_W-1:0]  rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (clk_en && wr_en)
      for (int b = 0; b < N_BYTES; b++)
        if (wr_be[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
  end

  // A write committing this edge is still pending for a read at the same edge.
  assign fwd_hit = wr_en && (wr_addr == rd_addr);
  assign rd_word = merge_bytes(mem[rd_addr], wr_data, fwd_hit ? wr_be : '0);
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [1:0]        bw_n,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  input  logic [17:0]       dq_i,
  output logic [17:0]       dq_o,
  output logic              dq_oe
);
  logic               sel_ok;
  op_e                cmd_op;
  logic [ADDR_W-1:0]  cmd_addr;
  op_e                s1_op, s2_op;
  logic [ADDR_W-1:0]  s1_addr, s2_addr;
  logic [N_BYTES-1:0] s1_be, s2_be;
  logic [WORD_W-1:0]  rd_word, rd_q;
  logic               drv_q;
  logic               fwd_hit;

  assign sel_ok = !sel1_n && sel2 && !sel3_n;

  sram_burst_ctl #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv(adv), .sel_ok(sel_ok),
    .we_n(we_n), .ilv(burst_ilv), .addr(addr),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  // Stage 1 holds the address phase, stage 2 the data phase of a write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s2_op   <= OP_IDLE;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_be   <= '0;
      s2_be   <= '0;
      rd_q    <= '0;
      drv_q   <= 1'b0;
    end else if (clk_en) begin
      s1_op   <= cmd_op;
      s1_addr <= cmd_addr;
      s1_be   <= ~bw_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      drv_q   <= (s1_op == OP_RD);
      if (s1_op == OP_RD) rd_q <= rd_word;
    end
  end

  sram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .clk_en(clk_en),
    .wr_en(s2_op == OP_WR), .wr_addr(s2_addr), .wr_be(s2_be), .wr_data(dq_i),
    .rd_addr(s1_addr), .fwd_hit(fwd_hit), .rd_word(rd_word)
  );

  assign dq_o  = rd_q;
  assign dq_oe = drv_q && !oe_n;

  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && s1_op == OP_RD) |=> drv_q);
  assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_op == OP_WR) |-> !drv_q);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(rd_q) && $stable(drv_q) && $stable(s2_op) && $stable(s1_addr)));
  assert_deselect_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv && !sel_ok) |=> (s1_op == OP_IDLE));
  assert_forward_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && s1_op == OP_RD && fwd_hit && s2_be == '1) |=> (rd_q == $past(dq_i)));
endmodule

// File: tb/pipe_sram_test.sv
`timescale 1ns/100ps
module pipe_sram_test;
  localparam int AW = 4;
  localparam int WW = 18;
  localparam logic [1:0] P_IDLE = 2'd0, P_RD = 2'd1, P_WR = 2'd2;
  localparam logic [2:0] CS_ON = 3'b010;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, clk_en, sel1_n, sel2, sel3_n, adv, we_n, burst_ilv, oe_n;
  logic [1:0]    bw_n;
  logic [AW-1:0] addr;
  logic [WW-1:0] dq_i, dq_o;
  logic          dq_oe;

  pipe_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .adv(adv), .we_n(we_n), .bw_n(bw_n), .burst_ilv(burst_ilv),
    .addr(addr), .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  int errs = 0, checks = 0, en_cnt = 0, wr_seq = 0;
  bit done = 0;
  logic [1:0]    ph_op  [4096];
  logic [WW-1:0] ph_val [4096];
  string         ph_tag [4096];
  logic [WW-1:0] shadow [16];
  logic [AW-1:0] b_base;
  logic [1:0]    b_step, b_op;
  logic          b_ilv;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] offs(input logic [1:0] s, input logic [1:0] c, input logic ilv);
    int v;
    v = ilv ? (int'(s) ^ int'(c)) : ((int'(s) + int'(c)) % 4);
    return 2'(v);
  endfunction

  function automatic logic [WW-1:0] pattern(input int n);
    return WW'(n * 40503 + 499);
  endfunction

  // One clock cycle: model the command, serve the data phase, check the bus.
  task automatic tick(input bit en, input bit ad, input logic [2:0] cs, input bit wen,
                      input logic [1:0] bwn, input bit ilv, input logic [AW-1:0] a,
                      input string tag, input bit probe);
    logic [1:0]    op;
    logic [AW-1:0] ea;
    logic [WW-1:0] d;
    int            k;
    string         t;
    clk_en = en; adv = ad; {sel1_n, sel2, sel3_n} = cs; we_n = wen;
    bw_n = bwn; burst_ilv = ilv; addr = a;
    if (en) begin
      if (!ad) begin
        op = (cs == CS_ON) ? (wen ? P_RD : P_WR) : P_IDLE;
        ea = a; b_base = a; b_step = 2'd0; b_ilv = ilv; b_op = op;
      end else begin
        b_step = b_step + 2'd1;
        op = b_op;
        ea = {b_base[AW-1:2], offs(b_base[1:0], b_step, b_ilv)};
      end
      ph_op[en_cnt] = op; ph_tag[en_cnt] = tag; ph_val[en_cnt] = '0;
      if (op == P_WR) begin
        d = pattern(wr_seq); wr_seq++;
        ph_val[en_cnt] = d;
        for (int b = 0; b < 2; b++)
          if (!bwn[b]) shadow[ea][b*9 +: 9] = d[b*9 +: 9];
      end else if (op == P_RD) begin
        ph_val[en_cnt] = shadow[ea];
      end
    end
    k = en_cnt - 2;
    t = !en ? "R8" : (k >= 0 ? ph_tag[k] : "R1");
    if (k >= 0 && ph_op[k] == P_WR) dq_i = ph_val[k];
    else dq_i = WW'(18'h2AAAA ^ WW'(en_cnt));
    #0.5;
    if (k >= 0 && ph_op[k] == P_RD) begin
      check(dq_oe === 1'b1, t, "read drive", WW'(dq_oe), 1);
      check(dq_o === ph_val[k], t, "read data", dq_o, ph_val[k]);
      if (probe) begin
        oe_n = 1'b1; #0.3;
        check(dq_oe === 1'b0, "R7", "oe_n high", WW'(dq_oe), 0);
        oe_n = 1'b0; #0.3;
        check(dq_oe === 1'b1, "R7", "oe_n low again", WW'(dq_oe), 1);
      end
    end else begin
      check(dq_oe === 1'b0, (k >= 0 && ph_op[k] == P_WR && en) ? "R6" : t,
            "drivers off", WW'(dq_oe), 0);
    end
    if (en) en_cnt++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int a, input string tag, input bit probe);
    tick(1, 0, CS_ON, 1, 2'b11, 0, AW'(a), tag, probe);
  endtask
  task automatic wr(input int a, input logic [1:0] bwn, input string tag);
    tick(1, 0, CS_ON, 0, bwn, 0, AW'(a), tag, 0);
  endtask
  task automatic idle(input string tag);
    tick(1, 0, 3'b111, 1, 2'b11, 0, '0, tag, 0);
  endtask
  task automatic adv_t(input logic [1:0] bwn, input string tag);
    // we_n and selects deliberately contradict the loaded command
    tick(1, 1, 3'b101, ~b_op[0], bwn, 1, AW'(15), tag, 0);
  endtask

  initial begin
    rst_n = 0; clk_en = 1; sel1_n = 1; sel2 = 0; sel3_n = 1; adv = 0; we_n = 1;
    bw_n = 2'b11; burst_ilv = 0; addr = '0; oe_n = 0; dq_i = '0;
    repeat (3) @(negedge clk);
    check(dq_oe === 1'b0, "R1", "reset drivers", WW'(dq_oe), 0);
    rst_n = 1;
    idle("R1"); idle("R1"); idle("R1");

    // R3 fill, then R2 readback with output-enable probes (R7)
    for (int a = 0; a < 16; a++) wr(a, 2'b00, "R3");
    for (int a = 0; a < 16; a++) rd(a, "R2", a % 3 == 0);
    idle("R2"); idle("R2");

    // R3/R4 byte-select sweep: forwarded, committed, and after another read
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 4; s++) begin
        wr(a, 2'(s), "R4"); rd(a, "R4", 0);
        wr(a + 4, 2'(s), "R3"); idle("R3"); rd(a + 4, "R3", 0);
        wr(a + 8, 2'(s), "R3"); rd(a, "R3", 0); rd(a + 8, "R3", 0);
      end

    // R4 strict alternation, mismatched and matched addresses
    for (int i = 0; i < 32; i++) begin
      wr(i % 16, 2'(i % 4), "R4");
      rd((i % 2 == 0) ? (i + 5) % 16 : i % 16, "R4", 0);
    end

    // R5 every chip-select combination on a write load
    for (int c = 0; c < 8; c++) begin
      tick(1, 0, 3'(c), 0, 2'b00, 0, AW'(3), "R5", 0);
      rd(3, "R5", 0);
      tick(1, 0, 3'(c), 1, 2'b00, 0, AW'(6), "R5", 0);
    end

    // R9/R10 read bursts from every start, both orders, with wrap
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        tick(1, 0, CS_ON, 1, 2'b11, m[0], AW'(8 + s), m ? "R10" : "R9", 0);
        for (int n = 0; n < 5; n++) adv_t(2'b11, m ? "R10" : "R9");
      end
    // R9/R10/R11 write bursts with per-beat byte selects, then read back
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        tick(1, 0, CS_ON, 0, 2'b00, m[0], AW'(4 + s), "R11", 0);
        for (int n = 0; n < 3; n++) adv_t(2'(n + 1), "R11");
        for (int a = 4; a < 8; a++) rd(a, m ? "R10" : "R9", 0);
      end
    // R11 advances after a deselected load stay idle
    tick(1, 0, 3'b110, 0, 2'b00, 0, AW'(12), "R11", 0);
    for (int n = 0; n < 4; n++) tick(1, 1, CS_ON, 0, 2'b00, 0, AW'(12), "R11", 0);
    for (int a = 12; a < 16; a++) rd(a, "R11", 0);

    // R8 irregular stalls with garbage commands
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 1 || i % 7 == 3)
        tick(0, i[0], 3'(i), i[1], 2'(i), i[2], AW'(i * 5), "R8", 0);
      else if (i % 2 == 0) wr((i * 3) % 16, 2'(i % 4), "R8");
      else rd((i * 3 + 3) % 16, "R8", i % 5 == 0);
    end
    for (int a = 0; a < 16; a++) rd(a, "R8", 0);
    idle("R2"); idle("R2"); idle("R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule